// File: doc/BRIEF.md
# Offset Nulling Approximation Sequencer

This block trims out the input offset of a differential preamplifier that feeds an external 8-bit converter. It drives a correction DAC code and two analog switch controls. One switch shorts the preamp input to zero. The other connects the live signal. When calibration starts, the block disconnects the signal and waits a guard gap. It then shorts the input and runs a binary search over the DAC code, from the most significant bit down to the least. Each trial sets one bit and waits a settle time. It then requests a conversion and reads back the byte. The trial bit is dropped if the byte is zero and kept if the byte holds any nonzero value. A zero byte means the converter saw its negative input at or above its positive one, so the preamp output was negative.

After the last bit the block opens the shorting switch and waits the guard gap again. It then reconnects the signal and pulses a completion flag. The final code stays applied to the DAC and can be read on a separate port until the next calibration. Every pin toward the analog board passes through an inverting buffer stage. The block therefore drives the bitwise complement of its internal code, and a switch pin driven low means that switch is closed.

The conversion request is a valid/ready pair. Once raised, the request stays high, with the DAC pins frozen, until the converter takes it. The result is a second valid/ready pair. The block raises its ready only while it waits for a result, and it ignores result data at every other time.

Top module: `offset_null_seq`

## Requirements
- R1: After reset the signal switch is closed (pin 0), the shorting switch is open (pin 1), the internal code is 0 (all DAC pins 1), and conv_req_valid, res_ready, cal_done and cal_busy are all 0.
- R2: A cal_start seen while idle raises cal_busy and opens the signal switch at the next clock edge. The shorting switch closes only after BBM_CYC full cycles with both switches open, and stays closed with the signal switch open whenever a conversion is requested.
- R3: Every change of the DAC pins is followed by at least SETTLE_CYC cycles before conv_req_valid rises.
- R4: Once raised, conv_req_valid stays high with the DAC pins unchanged until conv_req_ready is seen. res_ready is high only after a request has been taken and before a result is accepted, and it is never high together with conv_req_valid.
- R5: A calibration performs exactly CODE_W conversions. Trial k (k = 0 first) presents an internal code whose bits above position CODE_W-1-k hold the decisions already made, whose bit CODE_W-1-k is 1, and whose lower bits are 0.
- R6: An accepted result of 0 clears the current trial bit. Any nonzero result, of whatever value, keeps the bit. With a converter that reads nonzero exactly when the code is below a threshold T (0 to 256), the final code is 0 for T = 0 and min(T-1, 255) otherwise.
- R7: After the last decision the shorting switch opens. The signal switch closes only after BBM_CYC full cycles with both switches open. cal_done is high for exactly one cycle, the same cycle in which the signal switch closes, and cal_busy is then 0.
- R8: The two switches are never closed in the same cycle.
- R9: With the inverting pad stage (PAD_INVERT = 1), dac_drv is the bitwise complement of the internal code, and each switch pin is 0 when that switch is closed.
- R10: While idle, cal_code holds the last final code and the DAC keeps driving it. A cal_start seen during a calibration is ignored: one cal_done and one result per calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Begin calibration (taken only while idle) |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | One-cycle completion pulse |
| cal_code | output | CODE_W | Internal (non-inverted) correction code |
| dac_drv | output | CODE_W | DAC code pins after the pad stage |
| zero_sw_drv | output | 1 | Shorting switch pin, 0 = closed when inverted |
| sig_sw_drv | output | 1 | Signal switch pin, 0 = closed when inverted |
| conv_req_valid | output | 1 | Conversion request |
| conv_req_ready | input | 1 | Converter takes the request |
| res_valid | input | 1 | Conversion result present |
| res_ready | output | 1 | Block accepts a result |
| res_data | input | DATA_W | Converted byte |

## Verification
A wrong trial mask or a wrong keep decision appears on the DAC pins at the very next conversion request, so the bench compares every trial code against a search that it runs on its own. The threshold sweep covers every possible final code. A switch sequencing fault appears at the port in the cycle it happens, either as both pins low or as a guard gap shorter than required, and a short settle count appears as a request that rises too soon after a DAC change. A lost or extra decision shows up as a wrong number of requests or a missing completion pulse within one calibration.

// File: rtl/offset_null_pkg.sv
package offset_null_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRK_IN,
    ST_SETTLE,
    ST_REQ,
    ST_WAIT,
    ST_BRK_OUT
  } seq_state_e;

endpackage

// File: rtl/nul_timer.sv
module nul_timer #(
  parameter int TMR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic             expired
);

  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/nul_sar_reg.sv
module nul_sar_reg #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic              keep,
  output logic [CODE_W-1:0] code,
  output logic              last
);

  logic [CODE_W-1:0] code_q, mask_q;
  logic [CODE_W-1:0] code_d, mask_d;

  // Per bit: load the top trial, or resolve the current bit and arm the next one.
  for (genvar i = 0; i < CODE_W; i++) begin : g_bit
    logic resolved;
    assign resolved = code_q[i] & ~(mask_q[i] & ~keep);
    if (i == CODE_W - 1) begin : g_top
      assign code_d[i] = start ? 1'b1 : (step ? resolved : code_q[i]);
      assign mask_d[i] = start ? 1'b1 : (step ? 1'b0 : mask_q[i]);
    end else begin : g_low
      assign code_d[i] = start ? 1'b0 : (step ? (resolved | mask_q[i+1]) : code_q[i]);
      assign mask_d[i] = start ? 1'b0 : (step ? mask_q[i+1] : mask_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mask_q <= '0;
    end else begin
      code_q <= code_d;
      mask_q <= mask_d;
    end
  end

  assign code = code_q;
  assign last = mask_q[0];

endmodule

// File: rtl/nul_pad_drv.sv
module nul_pad_drv #(
  parameter int CODE_W     = 8,
  parameter int PAD_INVERT = 1
) (
  input  logic [CODE_W-1:0] code,
  input  logic              zero_closed,
  input  logic              sig_closed,
  output logic [CODE_W-1:0] dac_drv,
  output logic              zero_sw_drv,
  output logic              sig_sw_drv
);

  if (PAD_INVERT != 0) begin : g_inv
    for (genvar i = 0; i < CODE_W; i++) begin : g_pin
      assign dac_drv[i] = ~code[i];
    end
    assign zero_sw_drv = ~zero_closed;
    assign sig_sw_drv  = ~sig_closed;
  end else begin : g_true
    for (genvar i = 0; i < CODE_W; i++) begin : g_pin
      assign dac_drv[i] = code[i];
    end
    assign zero_sw_drv = zero_closed;
    assign sig_sw_drv  = sig_closed;
  end

endmodule

// File: rtl/offset_null_seq.sv
module offset_null_seq
  import offset_null_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int DATA_W     = 8,
  parameter int SETTLE_CYC = 4,
  parameter int BBM_CYC    = 3,
  parameter int PAD_INVERT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_start,
  output logic              cal_busy,
  output logic              cal_done,
  output logic [CODE_W-1:0] cal_code,
  output logic [CODE_W-1:0] dac_drv,
  output logic              zero_sw_drv,
  output logic              sig_sw_drv,
  output logic              conv_req_valid,
  input  logic              conv_req_ready,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data
);

  localparam int TMR_MAX = (SETTLE_CYC > BBM_CYC) ? SETTLE_CYC : BBM_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYC - 1);
  localparam logic [TMR_W-1:0] BBM_LD    = TMR_W'(BBM_CYC - 1);

  seq_state_e st_q, st_d;
  logic zero_cl_q, sig_cl_q, done_q;
  logic tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_val;
  logic sar_start, sar_step, sar_last, res_nonzero;
  logic [CODE_W-1:0] code;

  assign res_nonzero = |res_data;

  nul_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  nul_sar_reg #(.CODE_W(CODE_W)) u_sar (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sar_start),
    .step  (sar_step),
    .keep  (res_nonzero),
    .code  (code),
    .last  (sar_last)
  );

  nul_pad_drv #(.CODE_W(CODE_W), .PAD_INVERT(PAD_INVERT)) u_pad (
    .code        (code),
    .zero_closed (zero_cl_q),
    .sig_closed  (sig_cl_q),
    .dac_drv     (dac_drv),
    .zero_sw_drv (zero_sw_drv),
    .sig_sw_drv  (sig_sw_drv)
  );

  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    tmr_val   = BBM_LD;
    sar_start = 1'b0;
    sar_step  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cal_start) begin
          tmr_load = 1'b1;
          tmr_val  = BBM_LD;
          st_d     = ST_BRK_IN;
        end
      end
      ST_BRK_IN: begin
        if (tmr_exp) begin
          sar_start = 1'b1;
          tmr_load  = 1'b1;
          tmr_val   = SETTLE_LD;
          st_d      = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (tmr_exp) st_d = ST_REQ;
      end
      ST_REQ: begin
        if (conv_req_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (res_valid) begin
          sar_step = 1'b1;
          tmr_load = 1'b1;
          if (sar_last) begin
            tmr_val = BBM_LD;
            st_d    = ST_BRK_OUT;
          end else begin
            tmr_val = SETTLE_LD;
            st_d    = ST_SETTLE;
          end
        end
      end
      ST_BRK_OUT: begin
        if (tmr_exp) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      zero_cl_q <= 1'b0;
      sig_cl_q  <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= 1'b0;
      if (st_q == ST_IDLE && cal_start) sig_cl_q <= 1'b0;
      if (st_q == ST_BRK_IN && tmr_exp) zero_cl_q <= 1'b1;
      if (st_q == ST_WAIT && res_valid && sar_last) zero_cl_q <= 1'b0;
      if (st_q == ST_BRK_OUT && tmr_exp) begin
        sig_cl_q <= 1'b1;
        done_q   <= 1'b1;
      end
    end
  end

  assign conv_req_valid = (st_q == ST_REQ);
  assign res_ready      = (st_q == ST_WAIT);
  assign cal_busy       = (st_q != ST_IDLE);
  assign cal_done       = done_q;
  assign cal_code       = code;

endmodule

// File: rtl/offset_null_chk.sv
module offset_null_chk #(
  parameter int CODE_W     = 8,
  parameter int SETTLE_CYC = 4,
  parameter int BBM_CYC    = 3,
  parameter int PAD_INVERT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cal_busy,
  input logic              cal_done,
  input logic [CODE_W-1:0] cal_code,
  input logic [CODE_W-1:0] dac_drv,
  input logic              zero_sw_drv,
  input logic              sig_sw_drv,
  input logic              conv_req_valid,
  input logic              conv_req_ready,
  input logic              res_ready
);

  logic zero_on, sig_on;
  logic [15:0] open_run, since_chg;
  logic [CODE_W-1:0] dac_q;

  assign zero_on = (PAD_INVERT != 0) ? ~zero_sw_drv : zero_sw_drv;
  assign sig_on  = (PAD_INVERT != 0) ? ~sig_sw_drv  : sig_sw_drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_run  <= '0;
      since_chg <= 16'hFFFF;
      dac_q     <= (PAD_INVERT != 0) ? '1 : '0;
    end else begin
      if (!zero_on && !sig_on) open_run <= (open_run == 16'hFFFF) ? open_run : open_run + 1'b1;
      else                     open_run <= '0;
      dac_q <= dac_drv;
      if (dac_drv != dac_q)            since_chg <= 16'd1;
      else if (since_chg != 16'hFFFF)  since_chg <= since_chg + 1'b1;
    end
  end

  AST_SW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(zero_on && sig_on)); // R8
  AST_BBM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_on && !$past(zero_on)) |-> (open_run >= 16'(BBM_CYC))); // R2
  AST_BBM_SIG: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_on && !$past(sig_on)) |-> (open_run >= 16'(BBM_CYC))); // R7
  AST_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req_valid) |-> (since_chg >= 16'(SETTLE_CYC))); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_valid && !conv_req_ready) |=> (conv_req_valid && $stable(dac_drv))); // R4
  AST_RES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_ready && conv_req_valid)); // R4
  AST_REQ_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_valid |-> (zero_on && !sig_on)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done); // R7
  AST_DONE_SW: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (sig_on && !zero_on && !cal_busy)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_busy && $past(!cal_busy)) |-> $stable(cal_code)); // R10

endmodule

bind offset_null_seq offset_null_chk #(
  .CODE_W     (CODE_W),
  .SETTLE_CYC (SETTLE_CYC),
  .BBM_CYC    (BBM_CYC),
  .PAD_INVERT (PAD_INVERT)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cal_busy       (cal_busy),
  .cal_done       (cal_done),
  .cal_code       (cal_code),
  .dac_drv        (dac_drv),
  .zero_sw_drv    (zero_sw_drv),
  .sig_sw_drv     (sig_sw_drv),
  .conv_req_valid (conv_req_valid),
  .conv_req_ready (conv_req_ready),
  .res_ready      (res_ready)
);

// File: tb/offset_null_seq_bench.sv
module offset_null_seq_bench;

  localparam int CODE_W = 8;
  localparam int DATA_W = 8;
  localparam int SETTLE = 4;
  localparam int BBM    = 3;

  logic clk = 1'b0;
  logic rst_n, cal_start, conv_req_ready, res_valid;
  logic [DATA_W-1:0] res_data;
  logic cal_busy, cal_done, zero_sw_drv, sig_sw_drv, conv_req_valid, res_ready;
  logic [CODE_W-1:0] cal_code, dac_drv;

  int checks = 0;
  int failures = 0;
  int done_cnt = 0;
  int req_cnt = 0;

  always #2.5 clk = ~clk;

  offset_null_seq #(
    .CODE_W(CODE_W), .DATA_W(DATA_W), .SETTLE_CYC(SETTLE), .BBM_CYC(BBM), .PAD_INVERT(1)
  ) u_offset_null_seq (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cal_busy(cal_busy),
    .cal_done(cal_done), .cal_code(cal_code), .dac_drv(dac_drv),
    .zero_sw_drv(zero_sw_drv), .sig_sw_drv(sig_sw_drv),
    .conv_req_valid(conv_req_valid), .conv_req_ready(conv_req_ready),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Port monitor: switch exclusion, guard gaps, settle time, event counts.
  logic prev_zero = 1'b1, prev_sig = 1'b0, prev_req = 1'b0;
  logic [CODE_W-1:0] prev_dac = '1;
  int open_run = 0;
  int since_chg = 100000;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(!zero_sw_drv && !sig_sw_drv), "R8", "both switches closed", {zero_sw_drv, sig_sw_drv}, 2'b11);
      if (prev_zero && !zero_sw_drv) chk(open_run >= BBM, "R2", "gap before shorting switch", open_run, BBM);
      if (prev_sig && !sig_sw_drv)   chk(open_run >= BBM, "R7", "gap before signal switch", open_run, BBM);
      if (!prev_req && conv_req_valid) begin
        chk(since_chg >= SETTLE, "R3", "settle cycles before request", since_chg, SETTLE);
        req_cnt++;
      end
      if (cal_done) done_cnt++;
      open_run  = (zero_sw_drv && sig_sw_drv) ? open_run + 1 : 0;
      since_chg = (dac_drv != prev_dac) ? 1 : ((since_chg < 100000) ? since_chg + 1 : since_chg);
      prev_zero = zero_sw_drv;
      prev_sig  = sig_sw_drv;
      prev_req  = conv_req_valid;
      prev_dac  = dac_drv;
    end
  end

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic run_cal(input int t);
    int dly = t % 3;
    bit inj = (t % 37 == 5);
    logic [CODE_W-1:0] acc = '0;
    logic [CODE_W-1:0] trial;
    logic [CODE_W-1:0] d;
    int exp_final = (t == 0) ? 0 : ((t > 255) ? 255 : t - 1);
    int done0 = done_cnt;
    int req0 = req_cnt;
    int n;
    @(negedge clk) cal_start = 1'b1;
    @(negedge clk) cal_start = 1'b0;
    chk(cal_busy && sig_sw_drv && zero_sw_drv, "R2", "start opens signal switch first",
        {cal_busy, zero_sw_drv, sig_sw_drv}, 3'b111);
    for (int k = 0; k < CODE_W; k++) begin
      n = 0;
      while (!conv_req_valid && n < 500) begin @(negedge clk); n++; end
      if (n >= 500) begin chk(1'b0, "R5", "request timeout", k, CODE_W); return; end
      trial = acc | (8'h80 >> k);
      chk(~dac_drv == trial, "R5", "trial code order", ~dac_drv, trial);
      chk(dac_drv == ~trial, "R9", "inverted DAC pins", dac_drv, ~trial);
      chk(!zero_sw_drv && sig_sw_drv, "R2", "zeroed during conversion", {zero_sw_drv, sig_sw_drv}, 2'b01);
      for (int w = 0; w < dly; w++) begin
        @(negedge clk);
        chk(conv_req_valid && dac_drv == ~trial, "R4", "request held under back-pressure",
            {conv_req_valid, dac_drv}, {1'b1, ~trial});
      end
      conv_req_ready = 1'b1;
      @(negedge clk) conv_req_ready = 1'b0;
      chk(!conv_req_valid && res_ready, "R4", "request taken, result awaited",
          {conv_req_valid, res_ready}, 2'b01);
      for (int w = 0; w < dly; w++) @(negedge clk);
      chk(res_ready, "R4", "res_ready held while awaiting", res_ready, 1);
      if (trial < t) d = (t % 2 == 1) ? (8'h80 >> trial[2:0]) : 8'((t - trial > 255) ? 255 : t - trial);
      else           d = 8'h00;
      res_valid = 1'b1;
      res_data  = d;
      @(negedge clk);
      res_valid = 1'b0;
      res_data  = 8'h00;
      if (trial < t) acc = trial;  // R6: nonzero keeps the bit, zero clears it
      if (inj && k == 3) begin
        cal_start = 1'b1;
        @(negedge clk) cal_start = 1'b0;
      end
    end
    n = 0;
    while (!cal_done && n < 500) begin @(negedge clk); n++; end
    chk(cal_done && !sig_sw_drv && zero_sw_drv && !cal_busy, "R7", "done with signal switch closed",
        {cal_done, zero_sw_drv, sig_sw_drv, cal_busy}, 4'b1100);
    chk(cal_code == CODE_W'(exp_final), "R6", "final code for threshold", cal_code, exp_final);
    chk(cal_code == acc, "R6", "final code matches search", cal_code, acc);
    repeat (4) @(negedge clk);
    chk(!cal_done && !cal_busy, "R7", "done is one pulse", {cal_done, cal_busy}, 0);
    chk(done_cnt == done0 + 1, "R10", "one completion per calibration", done_cnt - done0, 1);
    chk(req_cnt == req0 + CODE_W, "R5", "conversions per calibration", req_cnt - req0, CODE_W);
    chk(cal_code == CODE_W'(exp_final) && dac_drv == ~CODE_W'(exp_final), "R10",
        "final code held and applied", {cal_code, dac_drv}, {CODE_W'(exp_final), ~CODE_W'(exp_final)});
  endtask

  initial begin
    rst_n = 1'b0;
    cal_start = 1'b0;
    conv_req_ready = 1'b0;
    res_valid = 1'b0;
    res_data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(!sig_sw_drv && zero_sw_drv, "R1", "reset switch state", {zero_sw_drv, sig_sw_drv}, 2'b10);
    chk(dac_drv == '1 && cal_code == '0, "R1", "reset code", {cal_code, dac_drv}, {8'h00, 8'hFF});
    chk(!conv_req_valid && !res_ready && !cal_done && !cal_busy, "R1", "reset handshake outputs",
        {conv_req_valid, res_ready, cal_done, cal_busy}, 0);
    for (int t = 0; t <= 256; t++) run_cal(t);
    summary();
    $finish;
  end

endmodule